// File: doc/BRIEF.md
# Vector element predication sequencer

This block walks the element positions of one vector register write for an element-wise operation with one or two sources. When it gets a start pulse it captures the resume index, the vector length, the element sizes, the register-group multiplier code, the register length in bytes and the policy bits. It then presents one element position per handshake to an external element datapath. Each position either asks for a computed result or asks for a fill value, and the block gives the byte write enables for that position.

Body positions run from the resume index up to the vector length. A body element whose predicate bit is clear is turned into a fill. Tail positions then run from the vector length up to a total count. That count comes from the multiplier, and when the multiplier is fractional the tail runs to the end of the physical register. A start that has nothing to do finishes at once. A reserved multiplier code is rejected.

Top module: `vec_pred_seq`

## Requirements
- R1: If `start_idx >= vec_len` on an accepted start, `done` is high in the same cycle as `start`. No element is presented, and `resume_idx` reads 0 afterwards.
- R2: Body positions are presented in ascending order, from `start_idx` to `vec_len-1`, with one position per accepted handshake (`el_valid && el_ready`). While `el_ready` is low, `el_valid` stays high and `el_idx` holds.
- R3: The predicate bit of element i is bit (i mod 64) of 64-bit word (i div 64), where word w sits at `mask_bits[64w+63:64w]`. With `use_mask=1` and that bit 0, the body position is presented with `el_fill=1`.
- R4: A masked-off body position has `el_we` equal to the full element byte mask when `mask_agn=1`, and `el_we=0` when `mask_agn=0`. An active body position has `el_fill=0` and the full element byte mask. With `use_mask=0` every body position is active.
- R5: Tail positions run from `vec_len` to `total-1` with `el_fill=1`. `el_we` is the full element byte mask when `tail_agn=1` and 0 otherwise. If total is at most `vec_len`, there is no tail.
- R6: `total = (vlenb << m) >> elem_log2`, where `m = max(0, elem_log2 - sew_log2 + L)` and L is `lmul_code` read as signed 3-bit: 000..011 give L = 0..3, and 101, 110, 111 give L = -3, -2, -1.
- R7: The full element byte mask is the low 2^`elem_log2` bits of `el_we`. When `el_fill=1`, `el_fill_val` has its low 8·2^`elem_log2` bits set to one and the other bits set to zero.
- R8: During the body, `resume_idx` equals `start_idx` plus the number of body positions accepted so far. It reads 0 once the body ends and whenever the block is idle.
- R9: `lmul_code=100` on a start raises `cfg_err` and `done` in that same cycle. No element is presented.
- R10: `done` pulses one cycle after the handshake of the final position, and `busy` is low from then on.
- R11: A `start` while `busy` is high is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse |
| start_idx | input | IW | Resume index of the first body element |
| vec_len | input | IW | Vector length |
| elem_log2 | input | 2 | log2 of destination element bytes |
| sew_log2 | input | 2 | log2 of selected element bytes |
| lmul_code | input | 3 | Signed log2 multiplier code |
| vlenb | input | IW | Register length in bytes |
| use_mask | input | 1 | 1 = predicate body elements with mask bits |
| mask_agn | input | 1 | Fill masked-off elements with ones |
| tail_agn | input | 1 | Fill tail elements with ones |
| mask_bits | input | 64*MASK_WORDS | Predicate bits, word 0 in the low bits |
| el_ready | input | 1 | Datapath accepts the current position |
| el_valid | output | 1 | A position is presented |
| el_idx | output | IW+6 | Element index |
| el_fill | output | 1 | 1 = write fill value, 0 = compute |
| el_we | output | 8 | Byte write enables |
| el_fill_val | output | 64 | Fill value |
| resume_idx | output | IW | Current resume index |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| cfg_err | output | 1 | Reserved multiplier code on start |

## Verification
If the position counter is corrupted, the error shows on `el_idx` at the next handshake, as a skipped or repeated index. It also shows as a wrong `resume_idx` on the same cycle. A mistake in the latched total appears as the wrong number of tail handshakes, and the `done` pulse then comes early or late. Policy or predicate faults show on the same cycle as a wrong `el_fill` or `el_we`, so every position is compared against a model of the rules while the datapath sometimes stalls.

// File: rtl/vec_pred_seq.sv
module vec_pred_seq #(
  parameter int IW = 16,
  parameter int MASK_WORDS = 4,
  localparam int TW = IW + 6,
  localparam int MBITS = 64 * MASK_WORDS,
  localparam int MIW = $clog2(MBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IW-1:0]    start_idx,
  input  logic [IW-1:0]    vec_len,
  input  logic [1:0]       elem_log2,
  input  logic [1:0]       sew_log2,
  input  logic [2:0]       lmul_code,
  input  logic [IW-1:0]    vlenb,
  input  logic             use_mask,
  input  logic             mask_agn,
  input  logic             tail_agn,
  input  logic [MBITS-1:0] mask_bits,
  input  logic             el_ready,
  output logic             el_valid,
  output logic [TW-1:0]    el_idx,
  output logic             el_fill,
  output logic [7:0]       el_we,
  output logic [63:0]      el_fill_val,
  output logic [IW-1:0]    resume_idx,
  output logic             busy,
  output logic             done,
  output logic             cfg_err
);

  typedef enum logic [1:0] {S_IDLE, S_BODY, S_TAIL} st_t;

  st_t           st;
  logic [TW-1:0] idx, vl_q, tot_q, tot_n;
  logic [1:0]    e_q;
  logic          um_q, ma_q, ta_q, done_q;
  logic [IW-1:0] res_q;
  logic signed [4:0] emul_s;
  logic [2:0]    emul;
  logic [7:0]    bmask;

  wire idle    = (st == S_IDLE);
  wire in_tail = (st == S_TAIL);
  wire illegal = (lmul_code == 3'b100);
  wire early   = (start_idx >= vec_len);
  wire go      = start && idle;
  wire mbit    = mask_bits[idx[MIW-1:0]];
  wire off     = (st == S_BODY) && um_q && !mbit;
  wire acc     = el_valid && el_ready;
  wire last_b  = (idx == vl_q - TW'(1));
  wire last_t  = (idx == tot_q - TW'(1));

  always_comb begin
    emul_s = $signed({3'b000, elem_log2}) - $signed({3'b000, sew_log2})
           + $signed({{2{lmul_code[2]}}, lmul_code});
    emul   = emul_s[4] ? 3'd0 : emul_s[2:0];
    tot_n  = (TW'(vlenb) << emul) >> elem_log2;
  end

  always_comb begin
    case (e_q)
      2'd0:    begin bmask = 8'h01; el_fill_val = 64'h0000_0000_0000_00FF; end
      2'd1:    begin bmask = 8'h03; el_fill_val = 64'h0000_0000_0000_FFFF; end
      2'd2:    begin bmask = 8'h0F; el_fill_val = 64'h0000_0000_FFFF_FFFF; end
      default: begin bmask = 8'hFF; el_fill_val = 64'hFFFF_FFFF_FFFF_FFFF; end
    endcase
  end

  assign el_valid   = !idle;
  assign busy       = !idle;
  assign el_idx     = idx;
  assign el_fill    = in_tail || off;
  assign el_we      = !el_fill ? bmask : ((in_tail ? ta_q : ma_q) ? bmask : 8'h00);
  assign resume_idx = res_q;
  assign cfg_err    = go && illegal;
  assign done       = done_q || (go && (illegal || early));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      vl_q   <= '0;
      tot_q  <= '0;
      e_q    <= '0;
      um_q   <= 1'b0;
      ma_q   <= 1'b0;
      ta_q   <= 1'b0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (go && !illegal) begin
          if (early) begin
            res_q <= '0;
          end else begin
            st    <= S_BODY;
            idx   <= TW'(start_idx);
            vl_q  <= TW'(vec_len);
            tot_q <= tot_n;
            e_q   <= elem_log2;
            um_q  <= use_mask;
            ma_q  <= mask_agn;
            ta_q  <= tail_agn;
            res_q <= start_idx;
          end
        end
        S_BODY: if (acc) begin
          idx <= idx + TW'(1);
          if (last_b) begin
            res_q <= '0;
            if (tot_q > vl_q) begin
              st <= S_TAIL;
            end else begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          end else begin
            res_q <= IW'(idx + TW'(1));
          end
        end
        S_TAIL: if (acc) begin
          idx <= idx + TW'(1);
          if (last_t) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module vec_pred_seq_chk #(
  parameter int IW = 16,
  parameter int TW = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          el_valid,
  input logic          el_ready,
  input logic [TW-1:0] el_idx,
  input logic          el_fill,
  input logic [7:0]    el_we,
  input logic [IW-1:0] resume_idx,
  input logic          busy,
  input logic          done,
  input logic          cfg_err
);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && !el_ready |=> el_valid && $stable(el_idx));

  // R2
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && el_ready |=> !el_valid || (el_idx == $past(el_idx) + TW'(1)));

  // R4
  active_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && !el_fill |-> el_we != 8'h00);

  // R9
  cfg_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> done && !busy);

  // R8
  idle_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> resume_idx == '0);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !el_valid);

endmodule

bind vec_pred_seq vec_pred_seq_chk #(.IW(IW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .el_valid(el_valid), .el_ready(el_ready),
  .el_idx(el_idx), .el_fill(el_fill), .el_we(el_we), .resume_idx(resume_idx),
  .busy(busy), .done(done), .cfg_err(cfg_err)
);

// File: tb/vec_pred_seq_tb.sv
`timescale 1ns/1ps
module vec_pred_seq_tb;

  localparam int IW = 16;
  localparam int TW = IW + 6;

  typedef struct packed {
    logic [15:0] st;
    logic [15:0] vl;
    logic [1:0]  e;
    logic [1:0]  s;
    logic [2:0]  lm;
    logic [15:0] vb;
    logic        um;
    logic        ma;
    logic        ta;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{16'd0, 16'd8,  2'd0, 2'd0, 3'b000, 16'd16, 1'b0, 1'b0, 1'b1},
    '{16'd2, 16'd10, 2'd1, 2'd1, 3'b001, 16'd16, 1'b1, 1'b1, 1'b0},
    '{16'd0, 16'd3,  2'd2, 2'd2, 3'b111, 16'd16, 1'b1, 1'b0, 1'b1},
    '{16'd5, 16'd70, 2'd0, 2'd0, 3'b010, 16'd32, 1'b1, 1'b1, 1'b1},
    '{16'd0, 16'd2,  2'd3, 2'd3, 3'b101, 16'd16, 1'b0, 1'b0, 1'b1},
    '{16'd1, 16'd6,  2'd1, 2'd0, 3'b000, 16'd16, 1'b1, 1'b1, 1'b0},
    '{16'd7, 16'd7,  2'd0, 2'd0, 3'b000, 16'd16, 1'b1, 1'b1, 1'b1},
    '{16'd0, 16'd1,  2'd0, 2'd1, 3'b110, 16'd16, 1'b1, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [IW-1:0] start_idx = '0, vec_len = '0, vlenb = '0;
  logic [1:0] elem_log2 = '0, sew_log2 = '0;
  logic [2:0] lmul_code = '0;
  logic use_mask = 1'b0, mask_agn = 1'b0, tail_agn = 1'b0, el_ready = 1'b1;
  logic [63:0] mw [4];
  logic [255:0] mask_bits;
  logic el_valid, el_fill, busy, done, cfg_err;
  logic [TW-1:0] el_idx;
  logic [7:0] el_we;
  logic [63:0] el_fill_val;
  logic [IW-1:0] resume_idx;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  initial begin
    mw[0] = 64'hDEAD_BEEF_C0DE_1357;
    mw[1] = 64'hFFFF_0000_FFFF_0000;
    mw[2] = 64'h0123_4567_89AB_CDEF;
    mw[3] = 64'hF0F0_3C3C_AAAA_5555;
  end
  assign mask_bits = {mw[3], mw[2], mw[1], mw[0]};

  vec_pred_seq #(.IW(IW), .MASK_WORDS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_idx(start_idx),
    .vec_len(vec_len), .elem_log2(elem_log2), .sew_log2(sew_log2),
    .lmul_code(lmul_code), .vlenb(vlenb), .use_mask(use_mask),
    .mask_agn(mask_agn), .tail_agn(tail_agn), .mask_bits(mask_bits),
    .el_ready(el_ready), .el_valid(el_valid), .el_idx(el_idx),
    .el_fill(el_fill), .el_we(el_we), .el_fill_val(el_fill_val),
    .resume_idx(resume_idx), .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit mbit(int i);
    return mw[i / 64][i % 64];
  endfunction

  task automatic run_case(input vec_t c, input bit stall, input bit poke);
    int lmv, emul, tot, endi, ei, cyc;
    bit fill_e;
    logic [7:0] bm, we_e;
    logic [63:0] fv;
    lmv  = c.lm[2] ? int'(c.lm) - 8 : int'(c.lm);
    emul = int'(c.e) - int'(c.s) + lmv;
    if (emul < 0) emul = 0;
    tot  = (int'(c.vb) << emul) >> c.e;
    endi = (tot > int'(c.vl)) ? tot : int'(c.vl);
    bm   = 8'((9'd1 << (1 << c.e)) - 9'd1);
    fv   = (c.e == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << c.e)) - 64'd1);
    @(negedge clk);
    start_idx = c.st; vec_len = c.vl; elem_log2 = c.e; sew_log2 = c.s;
    lmul_code = c.lm; vlenb = c.vb; use_mask = c.um; mask_agn = c.ma; tail_agn = c.ta;
    el_ready = 1'b1; start = 1'b1;
    #1;
    if (c.st >= c.vl) begin
      chk(done == 1'b1, "R1 early done", done, 1);
      @(negedge clk); start = 1'b0; #1;
      chk(el_valid == 1'b0, "R1 no element", el_valid, 0);
      chk(resume_idx == '0, "R1 resume cleared", resume_idx, 0);
      return;
    end
    chk(done == 1'b0, "R10 no early done", done, 0);
    @(negedge clk); start = 1'b0;
    ei = int'(c.st); cyc = 0;
    while (ei < endi && cyc < 5000) begin
      if (poke && cyc == 2) begin start = 1'b1; start_idx = '0; end
      else start = 1'b0;
      el_ready = stall ? (cyc % 3 != 1) : 1'b1;
      #1;
      chk(el_valid == 1'b1, "R2 valid during run", el_valid, 1);
      if (el_ready) begin
        chk(el_idx == TW'(ei), "R2 R5 R11 element index", el_idx, ei);
        if (ei < int'(c.vl)) begin
          fill_e = c.um && !mbit(ei);
          we_e   = fill_e ? (c.ma ? bm : 8'h00) : bm;
          chk(el_fill == fill_e, "R3 fill flag", el_fill, fill_e);
          chk(el_we == we_e, "R4 body write enables", el_we, we_e);
          chk(resume_idx == IW'(ei), "R8 resume index", resume_idx, ei);
        end else begin
          we_e = c.ta ? bm : 8'h00;
          chk(el_fill == 1'b1, "R5 tail fill flag", el_fill, 1);
          chk(el_we == we_e, "R5 tail write enables", el_we, we_e);
          chk(resume_idx == '0, "R8 resume in tail", resume_idx, 0);
        end
        if (el_fill) chk(el_fill_val == fv, "R7 fill value", el_fill_val, fv);
        ei++;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; el_ready = 1'b1;
    #1;
    chk(done == 1'b1, "R10 done after last element", done, 1);
    chk(busy == 1'b0, "R10 idle after done", busy, 0);
    chk(resume_idx == '0, "R8 resume zero at end", resume_idx, 0);
    chk(ei == endi, "R6 element count", ei, endi);
    @(negedge clk); #1;
    chk(done == 1'b0, "R10 done single pulse", done, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(el_valid == 1'b0 && busy == 1'b0, "R10 reset idle", {el_valid, busy}, 0);
    chk(done == 1'b0 && cfg_err == 1'b0, "R9 reset flags", {done, cfg_err}, 0);
    chk(resume_idx == '0, "R8 reset resume", resume_idx, 0);
    rst_n = 1'b1;

    for (int k = 0; k < 8; k++) run_case(TBL[k], 1'b0, 1'b0);

    // R2 stalls and R11 ignored start while busy
    run_case(TBL[3], 1'b1, 1'b1);
    run_case(TBL[1], 1'b1, 1'b0);

    // R9 reserved multiplier code
    @(negedge clk);
    start_idx = 0; vec_len = 4; lmul_code = 3'b100; vlenb = 16; start = 1'b1;
    #1;
    chk(cfg_err == 1'b1, "R9 cfg_err", cfg_err, 1);
    chk(done == 1'b1, "R9 done", done, 1);
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(el_valid == 1'b0, "R9 no element", el_valid, 0);
      chk(cfg_err == 1'b0, "R9 cfg_err pulse", cfg_err, 0);
      @(negedge clk);
    end

    // R1 start index beyond length
    run_case('{16'd9, 16'd4, 2'd0, 2'd0, 3'b000, 16'd16, 1'b0, 1'b0, 1'b0}, 1'b0, 1'b0);
    // R6 fractional multiplier clamped, tail to end of register
    run_case('{16'd3, 16'd5, 2'd1, 2'd1, 3'b101, 16'd16, 1'b1, 1'b0, 1'b1}, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule